// File: doc/BRIEF.md
# LFSR Memory Self-Test Checker

This block is a built-in test harness for a small single-port register file. It loops over the memory without stopping. First it makes a write pass over every address, writing words taken from a stimulus pseudo-random generator. Then it makes a read pass over the same addresses in the same order. A second generator, identical to the first and clocked by the same clock, produces the sequence the read data should follow. A registered flag reports, after each returned word, whether that word equalled the expected one. A sticky flag keeps the first disagreement until reset.

The memory itself sits outside the block and is reached through address, write-data, write-enable and read-data ports. The read latency of the memory is a parameter. For bring-up, a control input forces a known failure pattern. With it asserted, the expected word is inverted during every second pattern period. The flag then toggles at a fixed rate, which makes it easy to see on an oscilloscope or a logic trace.

Top module: `bist_lfsr_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: `match` reads 1, `fail` reads 0, `mem_addr` reads 0, the write pass is selected, and `mem_we` stays 0 for as long as reset is held.
- R2: Both generators are 5-bit shift registers with feedback polynomial x^5 + x^3 + 1. The next state is {s[3:0], s[4]^s[2]}. Both start from seed 5'b00001, so the sequence has period 31 and never reaches zero. Data bit i is state bit (i mod 5), which for 8-bit data gives {s[2:0], s}. The first nine written words are 21, 42, 84, 29, 52, A5, 6B, D6, 8C (hex).
- R3: Each enabled cycle issues one access. During the write pass, addresses run 0 to DEPTH-1 in ascending order with `mem_we` = 1, and the stimulus generator advances once per write. The read pass then covers 0 to DEPTH-1 with `mem_we` = 0. After that, the write pass starts again.
- R4: While `enable` is low, no access is issued: `mem_we` is 0, and the address and pass do not change.
- R5: A word read from the memory is compared RD_LAT cycles after its address was issued. It is compared against the reference generator, which advances once per comparison. `match` takes the result on the next clock edge and holds it until the next comparison.
- R6: `fail` goes to 1 on the same edge as any comparison that drives `match` low, injected ones included. Only reset clears it.
- R7: The reference periods are numbered from 0 after reset, and each period is 31 comparisons. While `inject` is 1, the expected word is fully inverted during odd-numbered periods. With `inject` held high and a healthy memory, `match` is therefore high for 31 comparisons and low for the next 31. With `inject` at 0, `match` stays high on a healthy memory.
- R8: If the memory returns a word with any bit wrong, `match` goes low after that comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Issue one memory access per cycle while high |
| inject | input | 1 | Invert the expected word on odd reference periods |
| mem_addr | output | ADDR_W | Address to the memory under test |
| mem_wdata | output | DATA_W | Write data to the memory under test |
| mem_we | output | 1 | Write enable to the memory under test |
| mem_rdata | input | DATA_W | Read data from the memory, valid RD_LAT cycles after the address |
| match | output | 1 | Registered result of the latest comparison |
| fail | output | 1 | Sticky mismatch flag |

## Verification
If the stimulus or reference generator drifts by even one state, or the two generators fall out of step, `match` falls within a few cycles. This happens on the first compared word after the drift, at the latest one read pass (DEPTH cycles) later. A wrong read-valid delay also shows at once, because it compares every word against its neighbour's expected value. If the period counter miscounts, the injected low window moves off its 31-comparison boundaries. The bench predicts the address, write data, `match` and `fail` on every cycle. It checks them during clean runs, pauses, injected runs and a corrupted memory bit.

// File: rtl/mbist_pkg.sv
// Shared definitions for the LFSR memory self-test checker.
// Assumes a 5-bit maximal-length generator (period 31).
package mbist_pkg;

    localparam int LFSR_W = 5;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef enum logic {
        PH_WRITE = 1'b0,
        PH_READ  = 1'b1
    } phase_e;

    // Next state for x^5 + x^3 + 1, shifting toward the MSB.
    function automatic lfsr_t lfsr_next(input lfsr_t s);
        return {s[LFSR_W-2:0], s[4] ^ s[2]};
    endfunction

endpackage

// File: rtl/lfsr_gen.sv
// Pattern generator: a 5-bit maximal-length shift register that advances
// once per cycle in which step is high.
// Assumes SEED is nonzero; the all-zero state is then unreachable.
module lfsr_gen
    import mbist_pkg::*;
#(
    parameter lfsr_t SEED = lfsr_t'(1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    output lfsr_t state
);

    // Load the seed on reset, otherwise advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED;
        else if (step)
            state <= lfsr_next(state);
    end

    a_r2_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state));

endmodule

// File: rtl/bist_seq.sv
// Address sequencer: sweeps 0..DEPTH-1 as a write pass, then as a read pass,
// and repeats. It issues one access per enabled cycle.
// Assumes DEPTH fits in ADDR_W bits.
module bist_seq
    import mbist_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    output logic [ADDR_W-1:0] addr,
    output phase_e            phase,
    output logic              wr_en,
    output logic              rd_issue
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic at_last;
    assign at_last = (addr == LAST);

    // Advance the address and flip the pass at the end of each sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            phase <= PH_WRITE;
        end else if (enable) begin
            if (at_last) begin
                addr  <= '0;
                phase <= (phase == PH_WRITE) ? PH_READ : PH_WRITE;
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end

    // Access strobes, suppressed in reset and while idle.
    always_comb begin
        wr_en    = rst_n && enable && (phase == PH_WRITE);
        rd_issue = rst_n && enable && (phase == PH_READ);
    end

    a_r3_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        enable && !at_last |=> addr == ADDR_W'($past(addr) + 1'b1) && $stable(phase));

    a_r3_sweep_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        enable && at_last |=> addr == '0 && phase != $past(phase));

    a_r4_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(addr) && $stable(phase));

    a_r3_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_issue));

endmodule

// File: rtl/bist_cmp.sv
// Comparator: delays each read issue by RD_LAT cycles, compares the returned
// word against the reference word, and registers match and a sticky fail.
// It counts reference periods and, when inject is set, inverts the expected
// word in odd periods.
// Assumes the memory returns data exactly RD_LAT cycles after the address.
module bist_cmp #(
    parameter int DATA_W = 8,
    parameter int RD_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic              inject,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] ref_word,
    input  logic              ref_wrap,
    output logic              ref_step,
    output logic              match,
    output logic              fail
);

    logic [RD_LAT-1:0] vld;
    logic              cmp_en;
    logic              odd_period;
    logic [DATA_W-1:0] expected;
    logic              hit;

    assign cmp_en = vld[RD_LAT-1];

    // Form the expected word and compare it with the returned word.
    always_comb begin
        expected = ref_word ^ {DATA_W{inject && odd_period}};
        hit      = (rdata == expected);
        ref_step = cmp_en;
    end

    // Track read validity, register the result, and count reference periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld        <= '0;
            match      <= 1'b1;
            fail       <= 1'b0;
            odd_period <= 1'b0;
        end else begin
            vld <= (vld << 1) | RD_LAT'(rd_issue);
            if (cmp_en) begin
                match <= hit;
                if (!hit)
                    fail <= 1'b1;
                if (ref_wrap)
                    odd_period <= ~odd_period;
            end
        end
    end

    a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> fail);

    a_r6_low_implies_fail: assert property (@(posedge clk) disable iff (!rst_n)
        !match |-> fail);

    a_r5_match_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable(match));

    a_r7_clean_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en && !inject && rdata == ref_word |=> match);

endmodule

// File: rtl/bist_lfsr_checker.sv
// Top of the LFSR memory self-test checker. A stimulus generator feeds the
// write pass; an identical reference generator, stepped once per compared
// read, supplies the expected words. The memory under test is external.
// Assumes RD_LAT < DEPTH, so a write never overtakes a pending read.
module bist_lfsr_checker
    import mbist_pkg::*;
#(
    parameter int    DEPTH  = 32,
    parameter int    DATA_W = 8,
    parameter int    RD_LAT = 1,
    parameter lfsr_t SEED   = lfsr_t'(1),
    parameter int    ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              inject,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              match,
    output logic              fail
);

    lfsr_t             stim_state;
    lfsr_t             ref_state;
    logic [DATA_W-1:0] stim_word;
    logic [DATA_W-1:0] ref_word;
    logic              wr_en;
    logic              rd_issue;
    logic              ref_step;
    logic              ref_wrap;
    phase_e            phase;

    bist_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .addr     (mem_addr),
        .phase    (phase),
        .wr_en    (wr_en),
        .rd_issue (rd_issue)
    );

    lfsr_gen #(.SEED(SEED)) u_stim (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (wr_en),
        .state (stim_state)
    );

    lfsr_gen #(.SEED(SEED)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ref_step),
        .state (ref_state)
    );

    // Spread the generator state over the data width: bit i takes bit i mod 5.
    for (genvar i = 0; i < DATA_W; i++) begin : g_spread
        assign stim_word[i] = stim_state[i % LFSR_W];
        assign ref_word[i]  = ref_state[i % LFSR_W];
    end

    // Flag the last reference state of each period.
    assign ref_wrap = (lfsr_next(ref_state) == SEED);

    bist_cmp #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (rd_issue),
        .inject   (inject),
        .rdata    (mem_rdata),
        .ref_word (ref_word),
        .ref_wrap (ref_wrap),
        .ref_step (ref_step),
        .match    (match),
        .fail     (fail)
    );

    assign mem_wdata = stim_word;
    assign mem_we    = wr_en;

    a_r4_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !mem_we);

    a_r3_write_pass_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> phase == PH_WRITE);

endmodule

// File: tb/bist_lfsr_checker_test.sv
`timescale 1ns/1ps
module bist_lfsr_checker_test;

    localparam int DEPTH = 32;
    localparam int AW    = 5;
    localparam int DW    = 8;
    localparam logic [7:0] WTAB [0:8] = '{8'h21, 8'h42, 8'h84, 8'h29, 8'h52,
                                         8'hA5, 8'h6B, 8'hD6, 8'h8C};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          inject = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic [DW-1:0] rdata;
    logic          match;
    logic          fail;

    logic [DW-1:0] mem [DEPTH];
    logic          corrupt = 1'b0;
    logic [AW-1:0] bad_addr = 5'd5;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    bist_lfsr_checker uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .inject(inject),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(rdata), .match(match), .fail(fail)
    );

    always #2.5 clk = ~clk;

    // Memory under test: one-cycle registered read, optional bit fault.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        rdata <= mem[mem_addr] ^ ((corrupt && mem_addr == bad_addr) ? 8'h10 : 8'h00);
    end

    function automatic logic [4:0] nxt(input logic [4:0] s);
        return {s[3:0], s[4] ^ s[2]};
    endfunction

    function automatic logic [7:0] word_of(input logic [4:0] s);
        return {s[2:0], s};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Cycle model built from the requirements.
    logic [AW-1:0] m_addr = '0;
    logic          m_phase = 1'b0;
    logic [4:0]    m_stim = 5'd1;
    logic [4:0]    m_ref = 5'd1;
    logic          m_odd = 1'b0;
    logic          m_pend = 1'b0;
    logic          m_match = 1'b1;
    logic          m_fail = 1'b0;
    logic [DW-1:0] m_exp;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr <= '0; m_phase <= 1'b0; m_stim <= 5'd1; m_ref <= 5'd1;
            m_odd <= 1'b0; m_pend <= 1'b0; m_match <= 1'b1; m_fail <= 1'b0;
        end else begin
            m_pend <= enable && m_phase;
            if (m_pend) begin
                m_exp = word_of(m_ref) ^ {DW{inject && m_odd}};
                m_match <= (rdata == m_exp);
                if (rdata != m_exp) m_fail <= 1'b1;
                m_ref <= nxt(m_ref);
                if (nxt(m_ref) == 5'd1) m_odd <= ~m_odd;
            end
            if (enable) begin
                if (!m_phase) m_stim <= nxt(m_stim);
                if (m_addr == AW'(DEPTH - 1)) begin
                    m_addr <= '0;
                    m_phase <= ~m_phase;
                end else begin
                    m_addr <= m_addr + 1'b1;
                end
            end
        end
    end

    // Per-cycle comparison of the ports against the model.
    always @(negedge clk) begin
        if (!done) begin
            chk(mem_addr == m_addr, "R3 address", mem_addr, m_addr);
            chk(mem_we == (rst_n && enable && !m_phase), "R4 write enable", mem_we, rst_n && enable && !m_phase);
            if (mem_we)
                chk(mem_wdata == word_of(m_stim), "R2 write data", mem_wdata, word_of(m_stim));
            chk(match == m_match, "R5/R7 match", match, m_match);
            chk(fail == m_fail, "R6 fail", fail, m_fail);
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;

        // R1: reset state
        repeat (3) tick();
        chk(match == 1'b1, "R1 match in reset", match, 1);
        chk(fail == 1'b0, "R1 fail in reset", fail, 0);
        chk(mem_addr == '0, "R1 address in reset", mem_addr, 0);
        chk(mem_we == 1'b0, "R1 no write in reset", mem_we, 0);
        enable = 1'b1;
        tick();
        chk(mem_we == 1'b0, "R1 no write while reset held", mem_we, 0);

        // R2/R3: first written words and addresses
        rst_n = 1'b1;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            chk(mem_addr == AW'(i), "R3 write address", mem_addr, i);
            chk(mem_wdata == WTAB[i], "R2 write word", mem_wdata, WTAB[i]);
            chk(mem_we == 1'b1, "R3 write strobe", mem_we, 1);
            tick();
        end

        // R5: clean rounds
        repeat (200) tick();
        chk(fail == 1'b0, "R5 clean memory", fail, 0);
        chk(match == 1'b1, "R5 clean match", match, 1);

        // R4: pause
        begin
            logic [AW-1:0] held;
            enable = 1'b0;
            tick();
            held = mem_addr;
            repeat (10) tick();
            chk(mem_addr == held, "R4 address frozen", mem_addr, held);
            chk(mem_we == 1'b0, "R4 no write when idle", mem_we, 0);
            enable = 1'b1;
        end
        repeat (100) tick();
        chk(fail == 1'b0, "R4 resume clean", fail, 0);

        // R7: injected pattern
        inject = 1'b1;
        do_reset();
        begin
            int lows = 0;
            int rises = 0;
            logic prev = 1'b1;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (!match) lows++;
                if (match && !prev) rises++;
                prev = match;
                tick();
            end
            chk(lows > 0, "R7 injected low window", lows, 1);
            chk(rises > 0, "R7 match returns high", rises, 1);
            chk(fail == 1'b1, "R6 fail after injection", fail, 1);
        end

        // R7: no injection keeps match high
        inject = 1'b0;
        do_reset();
        repeat (300) tick();
        chk(fail == 1'b0, "R7 inject off clean", fail, 0);

        // R8/R6: corrupted bit, then removed
        corrupt = 1'b1;
        do_reset();
        repeat (140) tick();
        chk(fail == 1'b1, "R8 corrupted word detected", fail, 1);
        corrupt = 1'b0;
        repeat (140) tick();
        chk(fail == 1'b1, "R6 fail stays set", fail, 1);
        chk(match == 1'b1, "R8 match recovers", match, 1);
        do_reset();
        @(negedge clk);
        chk(fail == 1'b0, "R6 reset clears fail", fail, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule